// File: doc/BRIEF.md
# Serial Port with Register File

This block is an asynchronous serial transmitter and receiver behind a small register file addressed by three bits. Software writes a byte to the transmit-data register, and the block frames it on the serial output. A frame is a low start bit, eight data bits sent least significant first, an optional parity bit, and one or two high stop bits. The receiver synchronises the serial input and confirms a start bit at half a bit period. It then samples every later bit at its centre and places each completed character in the receive-data register.

Software watches progress through a nine-bit status word. Its ready and empty flags follow the state of the data path. Its error flags are sticky and stay set until software writes to the status register. A control register of the same width holds one interrupt enable per status bit, and the interrupt output is high while any status bit and its enable are both set. The bit period is taken from a 16-bit divisor register. After reset the divisor is 1084, which gives 115200 bit/s from a 125 MHz clock, and the frame format defaults to two stop bits with no parity.

Top module: `sio_core`

## Requirements
- R1: Reads return the register selected by `reg_addr`. Address 0 gives the received byte in bits 7:0. Address 2 gives the status word. Address 3 gives back the 9-bit control value last written. Address 4 gives back the divisor. Address 1 and addresses 5 to 7 read as zero.
- R2: One bit lasts divisor+1 clock cycles. A transmitted frame is a low start bit, then data bits 0 to 7, then a parity bit when parity is enabled (even: XOR of the data; odd: its inverse), then STOP_BITS high bits. The line stays high while idle.
- R3: Status bit 1 (transmit holding register free) is clear while a written byte waits in the holding register. Status bit 2 (transmitter empty) is set only when the holding register is free and no frame is being shifted out.
- R4: A write to address 1 while status bit 1 is clear sets status bit 7 (transmit overrun) and discards the written byte, so no frame is ever sent for it.
- R5: A low level on the serial input is taken as a start bit only if it is still low half a bit period after it began. Shorter pulses are ignored. Data bits are sampled at mid-bit.
- R6: Status bit 0 (receive ready) is set when a character completes and cleared by a read of address 0.
- R7: If a character completes while status bit 0 is still set, status bit 6 (receive overrun) is set and the new character replaces the old one in the receive-data register.
- R8: Status bit 4 (framing error) is set when the first stop bit samples low. Status bit 5 (break) is set when the start bit, all data bits, any parity bit and the first stop bit all sample low.
- R9: With parity enabled, status bit 3 (parity error) is set when the received parity bit does not match the parity of the received data.
- R10: Any write to address 2 clears status bits 3 to 8 and leaves bits 0 to 2 unchanged.
- R11: Status bit 8 is the OR of status bits 3 to 7.
- R12: `irq` is high exactly when some status bit and the control bit in the same position are both 1.
- R13: After reset the divisor is DIV_RESET, the control register is 0, the status word is 0x006, the receive-data register is 0 and `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rd | input | 1 | Read strobe; a read of address 0 clears receive ready |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |

## Verification
The assertions assume that each bus cycle asserts at most one of `reg_wr` and `reg_rd`, and holds it for a single clock. They also assume that the serial input keeps each bit level for a whole period at the programmed divisor. The bench drives every bus access from a task that raises one strobe for exactly one cycle, away from the clock edge. Its frame generator holds each bit for divisor+1 cycles at a divisor that does not change during a frame. The only deliberate breaks in that timing are the short start-bit glitch, the low stop bit and the long low break, and each of these is separated from other traffic by idle periods.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam logic [2:0] A_RXD  = 3'd0;
   localparam logic [2:0] A_TXD  = 3'd1;
   localparam logic [2:0] A_STAT = 3'd2;
   localparam logic [2:0] A_CTRL = 3'd3;
   localparam logic [2:0] A_DIV  = 3'd4;

   localparam int NSTAT  = 9;
   localparam int S_RRDY = 0;
   localparam int S_TRDY = 1;
   localparam int S_TMT  = 2;
   localparam int S_PE   = 3;
   localparam int S_FE   = 4;
   localparam int S_BRK  = 5;
   localparam int S_ROE  = 6;
   localparam int S_TOE  = 7;
   localparam int S_ERR  = 8;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_t;
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
   parameter int DIV_W     = 16,
   parameter int PARITY    = 0,
   parameter int STOP_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             ld,
   input  logic [7:0]       ld_data,
   output logic             txd,
   output logic             trdy,
   output logic             tmt,
   output logic             ovr
);
   localparam int PB = (PARITY != 0) ? 1 : 0;
   localparam int FL = 1 + 8 + PB + STOP_BITS;
   localparam int BW = $clog2(FL);

   logic [7:0]       hold_q;
   logic             hold_full;
   logic             busy;
   logic [FL-1:0]    sh;
   logic [FL-1:0]    frame;
   logic [BW-1:0]    bcnt;
   logic [DIV_W-1:0] ccnt;

   generate
      if (PB == 0) begin : g_nopar
         assign frame = {{STOP_BITS{1'b1}}, hold_q, 1'b0};
      end else begin : g_par
         logic par_bit;
         assign par_bit = (^hold_q) ^ (PARITY == 2);
         assign frame   = {{STOP_BITS{1'b1}}, par_bit, hold_q, 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         hold_full <= 1'b0;
         busy      <= 1'b0;
         sh        <= '1;
         bcnt      <= '0;
         ccnt      <= '0;
      end else begin
         if (ld && !hold_full) begin
            hold_q    <= ld_data;
            hold_full <= 1'b1;
         end else if (!busy && hold_full) begin
            hold_full <= 1'b0;
         end
         if (!busy) begin
            if (hold_full) begin
               busy <= 1'b1;
               sh   <= frame;
               ccnt <= '0;
               bcnt <= '0;
            end
         end else if (ccnt == div) begin
            ccnt <= '0;
            sh   <= {1'b1, sh[FL-1:1]};
            if (bcnt == BW'(FL - 1)) busy <= 1'b0;
            else bcnt <= bcnt + 1'b1;
         end else begin
            ccnt <= ccnt + 1'b1;
         end
      end
   end

   assign txd  = busy ? sh[0] : 1'b1;
   assign trdy = !hold_full;
   assign tmt  = !hold_full && !busy;
   assign ovr  = ld && hold_full;

   AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (bcnt >= BW'(FL - STOP_BITS))) |-> txd); // R2
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int PARITY = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             rxd,
   output logic             done,
   output logic [7:0]       data,
   output logic             fe,
   output logic             brk,
   output logic             pe
);
   localparam int PB = (PARITY != 0) ? 1 : 0;
   localparam int NB = 8 + PB + 1;
   localparam int IW = $clog2(NB);

   rx_state_t        st;
   logic             rx_m, rx_s;
   logic [DIV_W-1:0] cnt;
   logic [IW-1:0]    idx;
   logic [NB-1:0]    sr;
   logic [NB-1:0]    sr_nx;
   logic             pe_nx;

   assign sr_nx = {rx_s, sr[NB-1:1]};

   generate
      if (PB == 0) begin : g_nopar
         assign pe_nx = 1'b0;
      end else begin : g_par
         assign pe_nx = (^sr_nx[8:0]) != (PARITY == 2);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_m <= 1'b1;
         rx_s <= 1'b1;
         st   <= RX_IDLE;
         cnt  <= '0;
         idx  <= '0;
         sr   <= '0;
         done <= 1'b0;
         data <= '0;
         fe   <= 1'b0;
         brk  <= 1'b0;
         pe   <= 1'b0;
      end else begin
         rx_m <= rxd;
         rx_s <= rx_m;
         done <= 1'b0;
         unique case (st)
            RX_IDLE: if (!rx_s) begin
               st  <= RX_START;
               cnt <= '0;
            end
            RX_START: if (cnt == (div >> 1)) begin
               cnt <= '0;
               idx <= '0;
               st  <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
               cnt <= cnt + 1'b1;
            end
            RX_BITS: if (cnt == div) begin
               cnt <= '0;
               sr  <= sr_nx;
               if (idx == IW'(NB - 1)) begin
                  done <= 1'b1;
                  data <= sr_nx[7:0];
                  fe   <= !rx_s;
                  brk  <= (sr_nx == '0);
                  pe   <= pe_nx;
                  st   <= rx_s ? RX_IDLE : RX_HOLD;
               end else begin
                  idx <= idx + 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            RX_HOLD: if (rx_s) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end

   AST_BRK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && brk) |-> fe); // R8
endmodule

// File: rtl/sio_core.sv
module sio_core
   import sio_pkg::*;
#(
   parameter int DIV_W     = 16,
   parameter int DIV_RESET = 1084,
   parameter int PARITY    = 0,
   parameter int STOP_BITS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        irq,
   output logic        txd,
   input  logic        rxd
);
   initial begin
      assert (DIV_W >= 2 && DIV_W <= 16) else $error("DIV_W must be 2..16");
      assert (PARITY >= 0 && PARITY <= 2) else $error("PARITY must be 0, 1 or 2");
      assert (STOP_BITS == 1 || STOP_BITS == 2) else $error("STOP_BITS must be 1 or 2");
      assert (DIV_RESET < (1 << DIV_W)) else $error("DIV_RESET exceeds divisor width");
   end

   logic [DIV_W-1:0] div_q;
   logic [NSTAT-1:0] ctrl_q;
   logic [NSTAT-1:0] stat;
   logic [7:0]       rxbuf;
   logic             rrdy, pe_q, fe_q, brk_q, roe_q, toe_q;
   logic             tx_rdy, tx_tmt, tx_ovr, tx_ld;
   logic             rx_done, rx_fe, rx_brk, rx_pe;
   logic [7:0]       rx_data;
   logic             wr_stat, rd_rx;

   assign tx_ld   = reg_wr && (reg_addr == A_TXD);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign rd_rx   = reg_rd && (reg_addr == A_RXD);

   sio_tx #(.DIV_W(DIV_W), .PARITY(PARITY), .STOP_BITS(STOP_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .div(div_q), .ld(tx_ld), .ld_data(reg_wdata[7:0]),
      .txd(txd), .trdy(tx_rdy), .tmt(tx_tmt), .ovr(tx_ovr));

   sio_rx #(.DIV_W(DIV_W), .PARITY(PARITY)) u_rx (
      .clk(clk), .rst_n(rst_n), .div(div_q), .rxd(rxd), .done(rx_done),
      .data(rx_data), .fe(rx_fe), .brk(rx_brk), .pe(rx_pe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(DIV_RESET);
         ctrl_q <= '0;
         rxbuf  <= '0;
         rrdy   <= 1'b0;
         pe_q   <= 1'b0;
         fe_q   <= 1'b0;
         brk_q  <= 1'b0;
         roe_q  <= 1'b0;
         toe_q  <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
         if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[NSTAT-1:0];
         if (rx_done) rxbuf <= rx_data;
         if (rx_done) rrdy <= 1'b1;
         else if (rd_rx) rrdy <= 1'b0;
         if (rx_done && rrdy && !rd_rx) roe_q <= 1'b1;
         else if (wr_stat) roe_q <= 1'b0;
         if (rx_done && rx_fe) fe_q <= 1'b1;
         else if (wr_stat) fe_q <= 1'b0;
         if (rx_done && rx_brk) brk_q <= 1'b1;
         else if (wr_stat) brk_q <= 1'b0;
         if (rx_done && rx_pe) pe_q <= 1'b1;
         else if (wr_stat) pe_q <= 1'b0;
         if (tx_ovr) toe_q <= 1'b1;
         else if (wr_stat) toe_q <= 1'b0;
      end
   end

   always_comb begin
      stat         = '0;
      stat[S_RRDY] = rrdy;
      stat[S_TRDY] = tx_rdy;
      stat[S_TMT]  = tx_tmt;
      stat[S_PE]   = pe_q;
      stat[S_FE]   = fe_q;
      stat[S_BRK]  = brk_q;
      stat[S_ROE]  = roe_q;
      stat[S_TOE]  = toe_q;
      stat[S_ERR]  = pe_q | fe_q | brk_q | roe_q | toe_q;
   end

   assign irq = |(stat & ctrl_q);

   always_comb begin
      unique case (reg_addr)
         A_RXD:   reg_rdata = {8'h00, rxbuf};
         A_STAT:  reg_rdata = 16'(stat);
         A_CTRL:  reg_rdata = 16'(ctrl_q);
         A_DIV:   reg_rdata = 16'(div_q);
         default: reg_rdata = '0;
      endcase
   end

   AST_RRDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !rx_done) |=> !rrdy); // R6
   AST_ROE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rrdy && !rd_rx) |=> roe_q); // R7
   AST_TOE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ld && !tx_rdy) |=> toe_q); // R4
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !rx_done) |=> (stat[S_ERR:S_PE] == '0)); // R10
   AST_TMT_NEEDS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tmt |-> tx_rdy); // R3
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_q != '0)); // R12
endmodule

// File: tb/sio_core_test.sv
module sio_core_test;
   localparam int DIV = 7;
   localparam int BP  = DIV + 1;

   logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0, rxd = 1'b1;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq, txd;
   logic [15:0] v;
   int          checks = 0, errors = 0, frames = 0;
   logic [7:0]  tx_q[$];

   always #4 clk = ~clk;

   sio_core #(.PARITY(1)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .txd(txd), .rxd(rxd));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(logic [2:0] a, logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(logic [2:0] a, output logic [15:0] val);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 val = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic send(logic [7:0] d, bit badpar, bit stoplow);
      logic [11:0] f;
      f = {1'b1, !stoplow, (^d) ^ badpar, d, 1'b0};
      for (int i = 0; i < 12; i++) begin
         rxd = f[i];
         repeat (BP) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (2 * BP) @(negedge clk);
   endtask

   // behavioural line monitor: expected frames come from the queue of accepted writes
   initial begin
      forever begin
         logic [7:0]  d;
         logic [11:0] fb;
         @(negedge txd);
         if (tx_q.size() == 0) begin
            chk("R4 unexpected frame", 1, 0);
            d = 8'h00;
         end else begin
            d = tx_q.pop_front();
         end
         fb = {2'b11, ^d, d, 1'b0};
         repeat (7) @(posedge clk);
         #1 chk("R2 start bit still low at cycle 7", txd, 0);
         @(posedge clk);
         #1 chk("R2 data bit 0 begins at cycle 8", txd, fb[1]);
         repeat (4) @(posedge clk);
         for (int j = 1; j < 12; j++) begin
            #1 chk($sformatf("R2 frame bit %0d", j), txd, fb[j]);
            if (j < 11) repeat (8) @(posedge clk);
         end
         frames++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 txd idle", txd, 1);
      chk("R13 irq", irq, 0);
      rreg(3'd2, v); chk("R13 status", v, 16'h006);
      rreg(3'd3, v); chk("R13 control", v, 0);
      rreg(3'd4, v); chk("R13 divisor", v, 1084);
      rreg(3'd0, v); chk("R13 rx data", v, 0);

      wreg(3'd4, DIV); rreg(3'd4, v); chk("R1 divisor readback", v, DIV);
      wreg(3'd3, 16'h1A5); rreg(3'd3, v); chk("R1 control readback", v, 16'h1A5);
      wreg(3'd3, 16'h0);
      rreg(3'd1, v); chk("R1 address 1 reads zero", v, 0);
      rreg(3'd6, v); chk("R1 address 6 reads zero", v, 0);

      tx_q.push_back(8'hA5); wreg(3'd1, 16'h00A5);
      rreg(3'd2, v); chk("R3 shifting, holding free", v, 16'h002);
      tx_q.push_back(8'h3C); wreg(3'd1, 16'h003C);
      rreg(3'd2, v); chk("R3 holding occupied", v, 16'h000);
      wreg(3'd1, 16'h00FF);
      rreg(3'd2, v); chk("R4 R11 overrun sets TOE and E", v, 16'h180);
      wreg(3'd2, 16'h0);
      rreg(3'd2, v); chk("R10 clear keeps TRDY/TMT", v, 16'h000);
      repeat (300) @(negedge clk);
      chk("R4 dropped byte not sent", frames, 2);
      rreg(3'd2, v); chk("R3 transmitter empty", v, 16'h006);

      send(8'h5A, 0, 0);
      rreg(3'd2, v); chk("R6 RRDY set", v, 16'h007);
      rreg(3'd0, v); chk("R5 received byte", v, 16'h005A);
      rreg(3'd2, v); chk("R6 RRDY cleared by read", v, 16'h006);

      rxd = 1'b0; repeat (2) @(negedge clk); rxd = 1'b1;
      repeat (3 * BP) @(negedge clk);
      rreg(3'd2, v); chk("R5 short pulse ignored", v, 16'h006);
      send(8'hC3, 0, 0);
      rreg(3'd0, v); chk("R5 byte after glitch", v, 16'h00C3);

      send(8'h11, 0, 0); send(8'h22, 0, 0);
      rreg(3'd2, v); chk("R7 R11 overrun", v, 16'h147);
      wreg(3'd2, 16'h0);
      rreg(3'd2, v); chk("R10 keeps RRDY", v, 16'h007);
      rreg(3'd0, v); chk("R7 newest byte kept", v, 16'h0022);

      send(8'h81, 0, 1);
      rreg(3'd2, v); chk("R8 framing error", v, 16'h117);
      rreg(3'd0, v); chk("R8 byte with bad stop", v, 16'h0081);
      wreg(3'd2, 16'h0);

      rxd = 1'b0; repeat (14 * BP) @(negedge clk); rxd = 1'b1;
      repeat (3 * BP) @(negedge clk);
      rreg(3'd2, v); chk("R8 break", v, 16'h137);
      rreg(3'd0, v); chk("R8 break data", v, 0);
      wreg(3'd2, 16'h0);

      send(8'h37, 1, 0);
      rreg(3'd2, v); chk("R9 parity error", v, 16'h10F);
      rreg(3'd0, v); chk("R9 byte with bad parity", v, 16'h0037);
      wreg(3'd2, 16'h0);
      rreg(3'd2, v); chk("R10 errors cleared", v, 16'h006);

      wreg(3'd3, 16'h010); @(negedge clk); chk("R12 enabled bit clear", irq, 0);
      wreg(3'd3, 16'h002); @(negedge clk); chk("R12 TRDY enabled", irq, 1);
      wreg(3'd3, 16'h001); @(negedge clk); chk("R12 RRDY enabled, empty", irq, 0);
      send(8'h44, 0, 0);
      chk("R12 irq on receive", irq, 1);
      rreg(3'd0, v);
      @(negedge clk); chk("R12 irq drops after read", irq, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule